// File: doc/BRIEF.md
# ADC Hardware Trigger Sequencer

This block is the digital control front end of a successive-approximation converter. A hardware trigger comes in asynchronous to the system clock. A set of one-hot select lines, one per status/control slot, decides which slot a trigger edge serves. On a qualified rising edge the sequencer starts a conversion with the chosen slot's channel. When the conversion finishes, it writes the result word into that slot's result register, sets the slot's complete flag and, if the slot allows it, raises the interrupt.

The analog converter is replaced by a stub engine. It takes a fixed number of cycles and returns a known function of the channel number. Software reaches the block through a slot-addressed configuration write port and a slot-addressed result read port. A write to any slot's configuration while a conversion is running aborts it. When the hardware-trigger enable input is low, a write to slot 0 starts a conversion at once, so there is a software start path as well.

The sequencer is a two-state machine. ST_IDLE waits for a start. Transition GO (ST_IDLE to ST_CONV) is taken on a hardware start or a software start. ST_CONV tracks the running conversion and has three exits:
- FINISH (ST_CONV to ST_IDLE) when the engine completes and the slot is in single mode.
- REPEAT (ST_CONV to ST_CONV, engine restarted) when the engine completes and the slot is in continuous mode.
- ABORT (ST_CONV to ST_IDLE) on any configuration write.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset, `busy`, `irq`, `sel_err` and every bit of `done_flags` are 0.
- R2: With `hw_trig_en`=1 in ST_IDLE, a rising edge of `hw_trig_in` while exactly one `trig_sel` bit i is high starts a conversion on slot i using slot i's channel. `busy` goes high until the conversion ends.
- R3: A trigger edge while no select bit is high, or while `hw_trig_en`=0, starts nothing.
- R4: A trigger edge arriving while `busy`=1 is ignored and is not stored for later.
- R5: A trigger edge in ST_IDLE with `hw_trig_en`=1 and two or more select bits high starts nothing and gives a one-cycle `sel_err` pulse.
- R6: On completion the result (channel*97+5) mod 2^RES_W is written to the active slot's result register, and `done_flags` bit i (slot i) is set. At most one flag becomes set per cycle, and only while a conversion was running.
- R7: `cfg_wr_data` holds the channel in bits [CH_W-1:0], the interrupt enable in bit CH_W and the continuous-mode bit in bit CH_W+1. `irq` is high exactly while some slot has both its flag and its enable set.
- R8: A slot's flag is cleared by a result read of that slot (`res_rd` with `res_rd_slot`) or by a configuration write to that slot.
- R9: In continuous mode conversions repeat back to back on the slot that started them, whatever the select lines do later, until a configuration write.
- R10: A configuration write while `busy`=1 aborts the conversion: `busy` is 0 in the next cycle and no result or flag is produced.
- R11: With `hw_trig_en`=0, a configuration write to slot 0 in ST_IDLE starts a conversion on slot 0 with the written channel. Writes to other slots start nothing.
- R12: The complete flag is set CONV_CYCLES clock edges after the edge that started the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_trig_in | input | 1 | Asynchronous hardware trigger |
| trig_sel | input | NS | One-hot slot select, bit i picks slot i |
| hw_trig_en | input | 1 | 1: hardware trigger path, 0: software start path |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wr_slot | input | SLOT_W | Slot addressed by the write |
| cfg_wr_data | input | CH_W+2 | {continuous, irq enable, channel} |
| res_rd | input | 1 | Result read strobe (clears the slot's flag) |
| res_rd_slot | input | SLOT_W | Slot addressed by the read |
| res_rd_data | output | RES_W | Result register of `res_rd_slot` |
| done_flags | output | NS | Per-slot conversion-complete flags |
| irq | output | 1 | Conversion-complete interrupt |
| busy | output | 1 | High while in ST_CONV |
| sel_err | output | 1 | One-cycle pulse on a multi-select trigger edge |

## Verification
The bench sends a second trigger edge, with a different select, into a running conversion. A design that queued it or re-steered the conversion would return an extra or misrouted result, and the scoreboard would catch it. It triggers with zero, one and two select lines high, which separates a design that converts on an ambiguous select from one that flags it. It also checks continuous mode by moving the select line mid-sequence and then aborting with a configuration write. This exposes a slot that follows the live select, and a conversion that still completes after the abort. Flag clearing is tested both by read and by configuration write. The start-to-flag latency is measured in clock edges, so an off-by-one in the engine counter shows up.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } seq_state_t;

    localparam int unsigned RES_MULT = 97;
    localparam int unsigned RES_OFFS = 5;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic meta_q, stab_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    assign rise = stab_q & ~prev_q;
endmodule

// File: rtl/adc_conv_engine.sv
module adc_conv_engine #(
    parameter int CH_W        = 5,
    parameter int RES_W       = 12,
    parameter int CONV_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [CH_W-1:0]  ch,
    output logic             done,
    output logic [RES_W-1:0] result
);
    import adc_trig_pkg::*;

    localparam int CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);
    localparam int PW = CH_W + RES_W + 8;

    logic             running;
    logic [CNT_W-1:0] cnt;
    logic [CH_W-1:0]  ch_q;
    logic [PW-1:0]    prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            ch_q    <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= LAST;
            ch_q    <= ch;
        end else if (abort || done) begin
            running <= 1'b0;
        end else if (running) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done   = running && (cnt == '0);
    assign prod   = PW'(ch_q) * PW'(RES_MULT) + PW'(RES_OFFS);
    assign result = prod[RES_W-1:0];
endmodule

// File: rtl/adc_slot_bank.sv
module adc_slot_bank #(
    parameter int NS     = 2,
    parameter int CH_W   = 5,
    parameter int RES_W  = 12,
    parameter int SLOT_W = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [SLOT_W-1:0]        cfg_wr_slot,
    input  logic [CH_W+1:0]          cfg_wr_data,
    input  logic                     res_rd,
    input  logic [SLOT_W-1:0]        res_rd_slot,
    input  logic                     cpl,
    input  logic [SLOT_W-1:0]        cpl_slot,
    input  logic [RES_W-1:0]         cpl_data,
    output logic [NS-1:0][CH_W-1:0]  slot_ch,
    output logic [NS-1:0]            slot_cont,
    output logic [NS-1:0]            flags,
    output logic [RES_W-1:0]         res_rd_data,
    output logic                     irq
);
    logic [NS-1:0][RES_W-1:0] res_q;
    logic [NS-1:0]            slot_ie;

    for (genvar i = 0; i < NS; i++) begin : g_slot
        logic wr_hit, rd_hit, cpl_hit;
        assign wr_hit  = cfg_wr && (cfg_wr_slot == SLOT_W'(i));
        assign rd_hit  = res_rd && (res_rd_slot == SLOT_W'(i));
        assign cpl_hit = cpl && (cpl_slot == SLOT_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_ch[i]   <= '0;
                slot_ie[i]   <= 1'b0;
                slot_cont[i] <= 1'b0;
                res_q[i]     <= '0;
                flags[i]     <= 1'b0;
            end else begin
                if (wr_hit) begin
                    slot_ch[i]   <= cfg_wr_data[CH_W-1:0];
                    slot_ie[i]   <= cfg_wr_data[CH_W];
                    slot_cont[i] <= cfg_wr_data[CH_W+1];
                end
                if (cpl_hit) begin
                    res_q[i] <= cpl_data;
                    flags[i] <= 1'b1;
                end else if (wr_hit || rd_hit) begin
                    flags[i] <= 1'b0;
                end
            end
        end
    end

    assign res_rd_data = res_q[res_rd_slot];
    assign irq         = |(flags & slot_ie);
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq #(
    parameter int NS          = 2,
    parameter int CH_W        = 5,
    parameter int RES_W       = 12,
    parameter int CONV_CYCLES = 16,
    localparam int SLOT_W     = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_trig_in,
    input  logic [NS-1:0]     trig_sel,
    input  logic              hw_trig_en,
    input  logic              cfg_wr,
    input  logic [SLOT_W-1:0] cfg_wr_slot,
    input  logic [CH_W+1:0]   cfg_wr_data,
    input  logic              res_rd,
    input  logic [SLOT_W-1:0] res_rd_slot,
    output logic [RES_W-1:0]  res_rd_data,
    output logic [NS-1:0]     done_flags,
    output logic              irq,
    output logic              busy,
    output logic              sel_err
);
    import adc_trig_pkg::*;

    seq_state_t state_q, state_d;
    logic [SLOT_W-1:0] act_q, sel_idx;
    logic trig_rise, sel_one, sel_many, hw_go, sw_go;
    logic eng_start, eng_abort, eng_done, cpl;
    logic [CH_W-1:0] start_ch;
    logic [RES_W-1:0] eng_res;
    logic [NS-1:0][CH_W-1:0] slot_ch;
    logic [NS-1:0] slot_cont;

    adc_trig_sync u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(hw_trig_in), .rise(trig_rise)
    );

    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < NS; i++)
            if (trig_sel[i]) sel_idx = SLOT_W'(i);
    end

    assign sel_one  = $onehot(trig_sel);
    assign sel_many = $countones(trig_sel) > 1;
    assign hw_go    = hw_trig_en && trig_rise && sel_one;
    assign sw_go    = !hw_trig_en && cfg_wr && (cfg_wr_slot == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (hw_go || sw_go) state_d = ST_CONV;
            ST_CONV: begin
                if (cfg_wr)                           state_d = ST_IDLE;
                else if (eng_done && !slot_cont[act_q]) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and active slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            act_q   <= '0;
            sel_err <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_err <= (state_q == ST_IDLE) && hw_trig_en && trig_rise && sel_many;
            if (state_q == ST_IDLE && hw_go)      act_q <= sel_idx;
            else if (state_q == ST_IDLE && sw_go) act_q <= '0;
        end
    end

    // outputs of the sequencer
    always_comb begin
        eng_start = 1'b0;
        eng_abort = 1'b0;
        cpl       = 1'b0;
        start_ch  = slot_ch[act_q];
        unique case (state_q)
            ST_IDLE: begin
                eng_start = hw_go || sw_go;
                start_ch  = sw_go ? cfg_wr_data[CH_W-1:0] : slot_ch[sel_idx];
            end
            ST_CONV: begin
                eng_abort = cfg_wr;
                cpl       = eng_done && !cfg_wr;
                eng_start = eng_done && !cfg_wr && slot_cont[act_q];
            end
            default: ;
        endcase
    end

    assign busy = (state_q == ST_CONV);

    adc_conv_engine #(.CH_W(CH_W), .RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .abort(eng_abort),
        .ch(start_ch), .done(eng_done), .result(eng_res)
    );

    adc_slot_bank #(.NS(NS), .CH_W(CH_W), .RES_W(RES_W), .SLOT_W(SLOT_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_wr_slot(cfg_wr_slot), .cfg_wr_data(cfg_wr_data),
        .res_rd(res_rd), .res_rd_slot(res_rd_slot),
        .cpl(cpl), .cpl_slot(act_q), .cpl_data(eng_res),
        .slot_ch(slot_ch), .slot_cont(slot_cont), .flags(done_flags),
        .res_rd_data(res_rd_data), .irq(irq)
    );
endmodule

// File: rtl/adc_trig_seq_chk.sv
module adc_trig_seq_chk #(
    parameter int NS = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          cfg_wr,
    input logic          sel_err,
    input logic [NS-1:0] done_flags,
    input logic          irq
);
    // R5
    sel_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |-> !busy);

    // R5
    sel_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |=> !sel_err);

    // R6
    flag_from_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_flags & ~$past(done_flags)) != '0) |-> $past(busy));

    // R6
    one_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_flags & ~$past(done_flags)));

    // R7
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done_flags != '0));

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr) |=> !busy);

    // R10
    abort_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr) |=> ((done_flags & ~$past(done_flags)) == '0));
endmodule

bind adc_trig_seq adc_trig_seq_chk #(.NS(NS)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cfg_wr(cfg_wr),
    .sel_err(sel_err), .done_flags(done_flags), .irq(irq)
);

// File: tb/adc_trig_seq_tb.sv
module adc_trig_seq_tb;
    localparam int NS = 2;
    localparam int CH_W = 5;
    localparam int RES_W = 12;
    localparam int CONV_CYCLES = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_trig_in = 1'b0;
    logic [NS-1:0] trig_sel = '0;
    logic hw_trig_en = 1'b0;
    logic cfg_wr = 1'b0;
    logic [0:0] cfg_wr_slot = '0;
    logic [CH_W+1:0] cfg_wr_data = '0;
    logic res_rd = 1'b0;
    logic [0:0] res_rd_slot = '0;
    logic [RES_W-1:0] res_rd_data;
    logic [NS-1:0] done_flags;
    logic irq, busy, sel_err;

    int checks = 0;
    int fails = 0;
    int err_pulses = 0;
    bit mon_en = 1'b1;

    typedef struct {
        int slot;
        logic [RES_W-1:0] data;
        bit ie;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    adc_trig_seq #(.NS(NS), .CH_W(CH_W), .RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES)) u_dut (
        .clk(clk), .rst_n(rst_n), .hw_trig_in(hw_trig_in), .trig_sel(trig_sel),
        .hw_trig_en(hw_trig_en), .cfg_wr(cfg_wr), .cfg_wr_slot(cfg_wr_slot),
        .cfg_wr_data(cfg_wr_data), .res_rd(res_rd), .res_rd_slot(res_rd_slot),
        .res_rd_data(res_rd_data), .done_flags(done_flags), .irq(irq),
        .busy(busy), .sel_err(sel_err)
    );

    function automatic logic [RES_W-1:0] model(input int ch);
        model = RES_W'((ch * 97 + 5) % (1 << RES_W));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg(input int slot, input int ch, input bit ie, input bit cont);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wr_slot = 1'(slot);
        cfg_wr_data = {cont, ie, 5'(ch)};
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        hw_trig_in = 1'b1;
        repeat (4) @(negedge clk);
        hw_trig_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_res(input int slot, input int ch, input bit ie);
        exp_t e;
        e.slot = slot;
        e.data = model(ch);
        e.ie = ie;
        q.push_back(e);
    endtask

    task automatic drain(input int extra);
        wait (q.size() == 0);
        repeat (extra) @(negedge clk);
    endtask

    // sel_err pulse counter
    always @(negedge clk) if (sel_err) err_pulses++;

    // monitor: reads each completed slot and compares against the queue
    initial begin
        int s;
        forever begin
            @(negedge clk);
            if (res_rd) begin
                // R8: read clears the flag
                check(done_flags[res_rd_slot] == 1'b0, "R8 read clear",
                      int'(done_flags[res_rd_slot]), 0);
                res_rd = 1'b0;
            end else if (mon_en && (done_flags != '0)) begin
                s = done_flags[0] ? 0 : 1;
                res_rd_slot = 1'(s);
                res_rd = 1'b1;
                #1;
                if (q.size() == 0) begin
                    check(1'b0, "R4/R10 unexpected result", s, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(s == e.slot, "R6 slot", s, e.slot);
                    check(res_rd_data == e.data, "R6 data", int'(res_rd_data), int'(e.data));
                    check(irq == e.ie, "R7 irq", int'(irq), int'(e.ie));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int lat;
        int e0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(busy == 0 && irq == 0 && sel_err == 0 && done_flags == 0, "R1 reset",
              int'({busy, irq, sel_err, done_flags}), 0);

        // configure both slots with hw path enabled (no start on write)
        hw_trig_en = 1'b1;
        cfg(0, 9, 1'b1, 1'b0);
        cfg(1, 20, 1'b0, 1'b0);

        // R3: edge without select
        trig_sel = '0;
        pulse_trig();
        check(busy == 0, "R3 no select", int'(busy), 0);

        // R3: edge with hw disabled
        hw_trig_en = 1'b0;
        trig_sel = 2'b01;
        pulse_trig();
        check(busy == 0, "R3 hw disabled", int'(busy), 0);
        hw_trig_en = 1'b1;

        // R2 slot A, plus R4 second edge with select B during busy
        expect_res(0, 9, 1'b1);
        pulse_trig();
        check(busy == 1, "R2 busy after start", int'(busy), 1);
        trig_sel = 2'b10;
        pulse_trig();
        trig_sel = '0;
        drain(30);
        check(busy == 0 && done_flags == 0, "R4 ignored edge", int'({busy, done_flags}), 0);

        // R2 slot B with interrupt off
        trig_sel = 2'b10;
        expect_res(1, 20, 1'b0);
        pulse_trig();
        trig_sel = '0;
        drain(5);
        check(irq == 0, "R7 irq off", int'(irq), 0);

        // R5: two selects
        trig_sel = 2'b11;
        pulse_trig();
        trig_sel = '0;
        repeat (20) @(negedge clk);
        check(err_pulses == 1, "R5 sel_err", err_pulses, 1);
        check(busy == 0 && done_flags == 0, "R5 no start", int'({busy, done_flags}), 0);

        // R9: continuous on slot B, select moved mid-sequence
        cfg(1, 7, 1'b1, 1'b1);
        trig_sel = 2'b10;
        expect_res(1, 7, 1'b1);
        expect_res(1, 7, 1'b1);
        expect_res(1, 7, 1'b1);
        pulse_trig();
        trig_sel = 2'b01;
        pulse_trig();
        trig_sel = '0;
        drain(1);
        check(busy == 1, "R9 still running", int'(busy), 1);
        cfg(1, 7, 1'b1, 1'b0);
        check(busy == 0, "R9 R10 abort ends continuous", int'(busy), 0);
        repeat (40) @(negedge clk);

        // R11 / R12: software start path and latency
        hw_trig_en = 1'b0;
        cfg(1, 3, 1'b0, 1'b0);
        check(busy == 0, "R11 slot1 write no start", int'(busy), 0);
        expect_res(0, 11, 1'b1);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wr_slot = 1'b0;
        cfg_wr_data = {1'b0, 1'b1, 5'd11};
        @(posedge clk);
        e0 = 0;
        @(negedge clk);
        cfg_wr = 1'b0;
        check(busy == 1, "R11 sw start", int'(busy), 1);
        lat = 0;
        while (!done_flags[0] && lat < 100) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        check(lat == CONV_CYCLES + e0, "R12 latency", lat, CONV_CYCLES);
        drain(3);

        // R10: abort a software-started conversion
        cfg(0, 2, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        check(busy == 1, "R10 running", int'(busy), 1);
        cfg(1, 4, 1'b0, 1'b0);
        check(busy == 0, "R10 abort", int'(busy), 0);
        repeat (30) @(negedge clk);
        check(done_flags == 0, "R10 no result", int'(done_flags), 0);

        // R8: flag cleared by configuration write
        mon_en = 1'b0;
        repeat (2) @(negedge clk);
        cfg(0, 13, 1'b1, 1'b0);
        repeat (CONV_CYCLES + 2) @(negedge clk);
        check(done_flags[0] == 1 && irq == 1, "R8 flag set", int'({done_flags[0], irq}), 3);
        hw_trig_en = 1'b1;
        cfg(1, 4, 1'b0, 1'b0);
        check(done_flags[0] == 1, "R8 other slot write keeps flag", int'(done_flags[0]), 1);
        cfg(0, 13, 1'b1, 1'b0);
        check(done_flags[0] == 0 && irq == 0 && busy == 0, "R8 write clear",
              int'({done_flags[0], irq, busy}), 0);

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R6 all results seen", q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule